// File: doc/BRIEF.md
# Time-Aware Stream Gate Controller

This block is the gate that sits in front of a single ingress stream. It works through a gate control list that repeats once per cycle. The cycle is anchored to a programmable base time and measured against a free-running time input made of 48 bits of seconds and 30 bits of nanoseconds. For each list entry, software sets:
- whether the gate is open or closed,
- an optional internal-priority override,
- the point in the cycle where the entry ends,
- a budget of octets the entry may pass.

For every frame presented, the block reports one verdict: pass or drop. A passing frame may also carry a priority override.

Software programs an administrative parameter set and the list entries through a small write port. A self-clearing change request copies the administrative set into the operational set that the gate uses. The copy happens only while an external update-enable input allows it. Software polls the pending flag to see when the change has taken effect. Before the base time is reached, and while the gate is disabled, the block applies an initial gate state and an initial priority selector.

Top module: `stream_gate`

## Requirements
- R1: After reset, `res_valid`, `res_pass`, `res_prio_vld` and `cfg_busy` are low, the operational set is all zero, and every frame is dropped.
- R2: A frame presented with `frm_valid` gets its verdict on `res_valid`/`res_pass` exactly one clock later. `res_valid` is high only in cycles that follow a presented frame.
- R3: Writing address 0x00 with bit 0 set raises `cfg_busy` on the next clock. While `upd_en` is low, `cfg_busy` stays high and the old operational set stays in force. In the first clock with `upd_en` high, the administrative set becomes operational and `cfg_busy` falls. The administrative registers are:
  - 0x01: base nanoseconds.
  - 0x02: low 32 bits of the base seconds.
  - 0x03: upper 16 bits of the base seconds.
  - 0x04: cycle time in nanoseconds.
  - 0x05: control word. Bit 0 is the gate enable, bit 1 is the initial open state, bits 5:2 are the initial selector, and bits 8 and up are the list length.
- R4: While the gate is disabled, before the base time, or with a cycle time of 0, each frame passes or drops by the initial open state, and a passing frame carries the initial selector.
- R5: From the base time on, the cycle position is (now − base) in nanoseconds modulo the cycle time. The active entry is the lowest-indexed entry, among the first list-length entries, whose cumulative end offset is greater than the position. If no entry matches, the frame is dropped.
- R6: A frame that arrives while the active entry is closed is dropped.
- R7: A 4-bit priority selector of 0 means no override. Otherwise bit 3 is set and bits 2:0 carry the priority. A passing frame raises `res_prio_vld` with `res_prio` equal to bits 2:0 only when bit 3 of the active selector is set. A dropped frame never raises it.
- R8: Octets passed in the active entry are counted. A frame is dropped when the count plus its length would exceed a nonzero octet maximum. A dropped frame adds nothing to the count, and a maximum of 0 means no limit.
- R9: The octet count restarts at zero whenever the active entry changes, and whenever the cycle position wraps to a value below the previous one.
- R10: The list entries are at address 0x40 + 4·index + field:
  - field 0: bit 0 is open, bits 4:1 are the selector.
  - field 1: cumulative end offset.
  - field 2: octet maximum.
  
  Entries take effect as soon as they are written. A write whose index is DEPTH or above changes no entry.
- R11: Applying an all-zero control word disables the gate, so every frame is dropped with no override.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| time_sec | input | 48 | Current time, seconds |
| time_ns | input | 30 | Current time, nanoseconds |
| upd_en | input | 1 | Allows a pending change to become operational |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 32 | Register write data |
| frm_valid | input | 1 | Frame query strobe |
| frm_len | input | LEN_W | Frame length in octets |
| cfg_busy | output | 1 | Change request pending |
| res_valid | output | 1 | Verdict valid |
| res_pass | output | 1 | Frame passes |
| res_prio_vld | output | 1 | Priority override present |
| res_prio | output | 3 | Overriding priority |

## Verification
A verdict is registered, so it appears in the cycle after the query, and the octet count is updated on that same edge. Time and the query are driven together on a falling edge, and the verdict is sampled on the next falling edge. `cfg_busy` rises one clock after the request write and falls one clock after `upd_en` allows the copy. The bench samples it at exactly those falling edges. After every configuration change, one frameless time step lets the design and the bench model settle on the same active entry before any counted frame.

// File: rtl/stream_gate.sv
module stream_gate #(
  parameter int DEPTH = 8,
  parameter int OCT_W = 16,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [47:0]      time_sec,
  input  logic [29:0]      time_ns,
  input  logic             upd_en,
  input  logic             wr_en,
  input  logic [7:0]       wr_addr,
  input  logic [31:0]      wr_data,
  input  logic             frm_valid,
  input  logic [LEN_W-1:0] frm_len,
  output logic             cfg_busy,
  output logic             res_valid,
  output logic             res_pass,
  output logic             res_prio_vld,
  output logic [2:0]       res_prio
);
  localparam int IDX_W = $clog2(DEPTH + 1);
  localparam logic [IDX_W-1:0] NONE = IDX_W'(DEPTH);

  typedef struct packed {
    logic [29:0]      ns;
    logic [47:0]      sec;
    logic [31:0]      ct;
    logic             en;
    logic             iopen;
    logic [3:0]       iips;
    logic [IDX_W-1:0] len;
  } par_t;

  par_t adm, opr;
  logic pend;

  logic             e_open [DEPTH];
  logic [3:0]       e_ips  [DEPTH];
  logic [31:0]      e_cum  [DEPTH];
  logic [OCT_W-1:0] e_max  [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adm  <= '0;
      opr  <= '0;
      pend <= 1'b0;
    end else begin
      if (pend && upd_en) begin
        opr  <= adm;
        pend <= 1'b0;
      end
      if (wr_en) begin
        case (wr_addr)
          8'h00: if (wr_data[0]) pend <= 1'b1;
          8'h01: adm.ns <= wr_data[29:0];
          8'h02: adm.sec[31:0] <= wr_data;
          8'h03: adm.sec[47:32] <= wr_data[15:0];
          8'h04: adm.ct <= wr_data;
          8'h05: begin
            adm.en    <= wr_data[0];
            adm.iopen <= wr_data[1];
            adm.iips  <= wr_data[5:2];
            adm.len   <= wr_data[8 +: IDX_W];
          end
          default: ;
        endcase
      end
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    wire sel = wr_en && (wr_addr[7:6] == 2'b01) && (wr_addr[5:2] == 4'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        e_open[g] <= 1'b0;
        e_ips[g]  <= '0;
        e_cum[g]  <= '0;
        e_max[g]  <= '0;
      end else if (sel) begin
        case (wr_addr[1:0])
          2'd0: begin
            e_open[g] <= wr_data[0];
            e_ips[g]  <= wr_data[4:1];
          end
          2'd1: e_cum[g] <= wr_data;
          2'd2: e_max[g] <= wr_data[OCT_W-1:0];
          default: ;
        endcase
      end
    end
  end

  logic        after, sched;
  logic [79:0] el;
  logic [31:0] pos;

  assign after = {time_sec, time_ns} >= {opr.sec, opr.ns};
  assign el    = 80'(time_sec - opr.sec) * 80'd1000000000 + 80'(time_ns) - 80'(opr.ns);
  assign pos   = (opr.ct == '0) ? '0 : 32'(el % 80'(opr.ct));
  assign sched = opr.en && after && (opr.ct != '0);

  logic [IDX_W-1:0] cur, last_idx;
  logic             a_open;
  logic [3:0]       a_ips;
  logic [OCT_W-1:0] a_max;

  always_comb begin
    cur    = NONE;
    a_open = sched ? 1'b0 : opr.iopen;
    a_ips  = sched ? 4'd0 : opr.iips;
    a_max  = '0;
    if (sched)
      for (int i = DEPTH - 1; i >= 0; i--)
        if (IDX_W'(i) < opr.len && pos < e_cum[i]) begin
          cur    = IDX_W'(i);
          a_open = e_open[i];
          a_ips  = e_ips[i];
          a_max  = e_max[i];
        end
  end

  logic [31:0] cnt, last_pos, cnt_base;
  logic [32:0] sum;
  logic        over, ok;

  assign cnt_base = (cur != last_idx || pos < last_pos) ? '0 : cnt;
  assign sum      = {1'b0, cnt_base} + 33'(frm_len);
  assign over     = (a_max != '0) && (sum > 33'(a_max));
  assign ok       = a_open && !over;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_idx     <= NONE;
      last_pos     <= '0;
      cnt          <= '0;
      res_valid    <= 1'b0;
      res_pass     <= 1'b0;
      res_prio_vld <= 1'b0;
      res_prio     <= '0;
    end else begin
      last_idx     <= cur;
      last_pos     <= pos;
      cnt          <= (frm_valid && ok) ? sum[31:0] : cnt_base;
      res_valid    <= frm_valid;
      res_pass     <= frm_valid && ok;
      res_prio_vld <= frm_valid && ok && a_ips[3];
      res_prio     <= a_ips[2:0];
    end
  end

  assign cfg_busy = pend;
endmodule

// File: rtl/stream_gate_chk.sv
module stream_gate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        upd_en,
  input logic        wr_en,
  input logic [7:0]  wr_addr,
  input logic [31:0] wr_data,
  input logic        frm_valid,
  input logic        cfg_busy,
  input logic        res_valid,
  input logic        res_pass,
  input logic        res_prio_vld
);
  wire req = wr_en && (wr_addr == 8'h00) && wr_data[0];

  assert_verdict_due_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |=> res_valid);
  assert_no_stray_verdict_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_valid |=> !res_valid);
  assert_pass_is_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    res_pass |-> res_valid);
  assert_override_needs_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_prio_vld |-> res_pass);
  assert_request_raises_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> cfg_busy);
  assert_busy_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_busy && !upd_en) |=> cfg_busy);
  assert_busy_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_busy && upd_en && !req) |=> !cfg_busy);
endmodule

bind stream_gate stream_gate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .frm_valid(frm_valid), .cfg_busy(cfg_busy),
  .res_valid(res_valid), .res_pass(res_pass), .res_prio_vld(res_prio_vld)
);

// File: tb/stream_gate_test.sv
module stream_gate_test;
  logic        clk = 0, rst_n = 0;
  logic [47:0] time_sec = '0;
  logic [29:0] time_ns = '0;
  logic        upd_en = 0, wr_en = 0, frm_valid = 0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [15:0] frm_len = '0;
  logic        cfg_busy, res_valid, res_pass, res_prio_vld;
  logic [2:0]  res_prio;

  stream_gate uut (.*);

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model of the operational set
  int m_bsec = 0, m_bns = 0, m_ct = 0, m_len = 0;
  bit m_en = 0, m_iopen = 0;
  int m_iips = 0;
  bit m_open[8];
  int m_ips[8], m_cum[8], m_max[8];
  int m_lidx = 8, m_lpos = 0;
  longint m_cnt = 0;

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1; wr_addr = 8'(a); wr_data = 32'(d);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic step(input int s, input int n, input bit f, input int l, input string tag);
    bit after, sch, open, over, ok;
    longint el;
    int pos, idx, ips, mx;
    longint ce;
    string cause;
    @(negedge clk);
    time_sec = 48'(s); time_ns = 30'(n); frm_valid = f; frm_len = 16'(l);
    after = (s > m_bsec) || (s == m_bsec && n >= m_bns);
    sch = m_en && after && m_ct != 0;
    el = longint'(s - m_bsec) * 1000000000 + n - m_bns;
    pos = (m_ct == 0) ? 0 : int'(el % m_ct);
    idx = 8; open = m_iopen; ips = m_iips; mx = 0;
    if (sch) begin
      open = 0; ips = 0;
      for (int i = 0; i < m_len && i < 8; i++)
        if (pos < m_cum[i]) begin
          idx = i; open = m_open[i]; ips = m_ips[i]; mx = m_max[i];
          break;
        end
    end
    ce = (idx != m_lidx || pos < m_lpos) ? 0 : m_cnt;
    over = (mx != 0) && (ce + l > mx);
    ok = open && !over;
    m_cnt = (f && ok) ? ce + l : ce;
    m_lidx = idx; m_lpos = pos;
    cause = !open ? "R6" : over ? "R8" : sch ? "R5" : "R4";
    @(negedge clk);
    frm_valid = 0;
    if (f) begin
      chk({tag, " R2 valid"}, res_valid, 1);
      chk({tag, " ", cause, " pass"}, res_pass, ok);
      chk({tag, " R7 override"}, res_prio_vld, ok && ips[3]);
      if (ok && ips[3]) chk({tag, " R7 prio"}, res_prio, ips & 7);
    end
  endtask

  task automatic set_entry(input int i, input bit o, input int ips, input int cum, input int mx);
    wr(8'h40 + 4 * i, (ips << 1) | o);
    wr(8'h41 + 4 * i, cum);
    wr(8'h42 + 4 * i, mx);
    if (i < 8) begin
      m_open[i] = o; m_ips[i] = ips; m_cum[i] = cum; m_max[i] = mx;
    end
  endtask

  task automatic apply(input string tag);
    wr(0, 1);
    chk({tag, " R3 busy after request"}, cfg_busy, 1);
    @(negedge clk);
    chk({tag, " R3 busy cleared"}, cfg_busy, 0);
  endtask

  // position helper inside the programmed schedule (base 5 s + 100 ns, cycle 1000)
  task automatic at(input int k, input int p, input bit f, input int l, input string tag);
    step(5, 100 + 1000 * k + p, f, l, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 res_valid", res_valid, 0);
    chk("R1 cfg_busy", cfg_busy, 0);
    step(0, 0, 1, 10, "R1 default drop");

    // R3: request held while updates are not allowed
    wr(5, (1 << 1) | (4'hA << 2));
    wr(0, 1);
    chk("R3 busy raised", cfg_busy, 1);
    repeat (3) @(negedge clk);
    chk("R3 busy held", cfg_busy, 1);
    step(0, 0, 1, 10, "R3 old set in force");
    upd_en = 1;
    @(negedge clk);
    chk("R3 busy falls", cfg_busy, 0);
    m_iopen = 1; m_iips = 4'hA;
    step(0, 0, 1, 10, "R4 disabled uses initial");
    @(negedge clk);
    chk("R2 no stray verdict", res_valid, 0);

    // schedule: base 5 s + 100 ns, cycle 1000 ns, three entries
    wr(1, 100); wr(2, 5); wr(3, 0); wr(4, 1000);
    set_entry(0, 1, 0, 300, 0);
    set_entry(1, 0, 0, 600, 0);
    set_entry(2, 1, 4'hD, 1000, 200);
    set_entry(8, 0, 0, 50, 7);    // R10: beyond depth, must be ignored
    wr(5, 1 | (3 << 8));
    apply("sched");
    m_bsec = 5; m_bns = 100; m_ct = 1000; m_en = 1; m_iopen = 0; m_iips = 0; m_len = 3;
    step(4, 999, 1, 10, "R4 before base sec");
    step(5, 50, 1, 10, "R4 before base ns");
    at(0, 10, 1, 10, "R10 entry0 unaliased");

    for (int p = 0; p < 1000; p += 3) at(3, p, 1, 10, "sweep");
    for (int n = 0; n < 1000; n += 37) step(6, n, 1, 10, "second crossing");

    // octet budget on entry 2 (max 200)
    at(5, 100, 0, 0, "");
    at(5, 650, 1, 100, "R8 first");
    at(5, 660, 1, 100, "R8 reaches max");
    at(5, 670, 1, 1, "R8 over");
    chk("R8 over literal", res_pass, 0);
    at(5, 680, 1, 0, "R8 zero length");
    at(5, 100, 1, 5, "R9 leave entry");
    at(5, 700, 1, 150, "R9 reset on entry change");
    chk("R9 literal", res_pass, 1);
    at(5, 900, 1, 40, "R9 fill");
    at(6, 650, 1, 150, "R9 reset on wrap");
    chk("R9 wrap literal", res_pass, 1);

    // R5: shorter list leaves a tail with no entry
    wr(5, 1 | (2 << 8));
    apply("len2");
    m_len = 2;
    at(7, 0, 0, 0, "");
    at(7, 800, 1, 10, "R5 no matching entry");
    chk("R5 literal drop", res_pass, 0);
    at(7, 100, 1, 10, "R5 entry0 still");

    // R11: all-zero control word
    wr(5, 0);
    apply("zero");
    m_en = 0; m_iopen = 0; m_iips = 0; m_len = 0;
    at(8, 0, 0, 0, "");
    for (int p = 0; p < 1000; p += 125) at(8, p, 1, 10, "R11 zero config");
    chk("R11 no override", res_prio_vld, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule